// File: doc/BRIEF.md
# Serial-Loaded LED Channel Driver Core with Fault Readback

This block is the digital heart of a sixteen-channel LED sink driver. A host shifts channel data in one bit per rising clock edge, and the block passes it on through a serial output so that several drivers can share one daisy chain. A level-sensitive latch moves the shifted word to the channel stage. An active-low enable then switches each channel on or blanks all of them at once. The analog current sinks sit outside the block. Each channel-on bit drives one of them.

The latch and enable pins have a second job. When the two pins take a fixed pattern over five consecutive clock edges, the block switches into a diagnostic mode. A second pattern switches it back. In diagnostic mode the host loads and latches all ones, pulses the enable low, and then returns it high. On that rising step the block loads a per-channel health word into the shift register, taken from the external fault flags. The host reads the word back through the serial output in the same format as ordinary data.

Top module: `led_sink_core`

## Requirements
- R1: On each rising clock edge the register moves up one stage, and `ser_in` enters stage 0. `ser_out` always shows stage 15. A bit sampled on one edge therefore appears on `ser_out` after the 16th edge, counting the edge that sampled it.
- R2: While `latch_dm` is high, the latch follows the shift register. While it is low, the latch holds its contents. Latch bit i drives `chan_on[i]`, so stage 15 drives channel 15.
- R3: While `oen_dm` is high, `chan_on` is all zero. While it is low, `chan_on` equals the latch.
- R4: The block enters diagnostic mode when five consecutive edges sample the (`oen_dm`, `latch_dm`) pairs (1,0), (0,0), (1,0), (1,1), (1,0), oldest first. Shifting of `ser_in` continues from the next edge.
- R5: The block returns to normal mode when five consecutive edges sample `oen_dm` as 1, 0, 1, 1, 1 with `latch_dm` low on all five.
- R6: An entry pattern seen in diagnostic mode has no effect, and a return pattern seen in normal mode has no effect. In particular, a repeated entry pattern does not re-arm the capture.
- R7: In diagnostic mode, the first edge that samples `oen_dm` high after an edge that sampled it low loads the shift register instead of shifting. Bit i becomes 1 when `fault_flags[i]` is 0 (healthy) and 0 when it is 1 (open or short). The word then shifts out on `ser_out`, bit 15 first.
- R8: Only one capture happens per stay in diagnostic mode, and none happens in normal mode. Later enable pulses shift as usual.
- R9: While `rst_n` is low at a rising edge, the shift register, the latch and the pattern history clear and the block returns to normal mode. `ser_out` then reads 0, and `chan_on` reads 0.
- R10: Matching checks the last five sampled pairs on every edge. A broken attempt whose later pairs begin a valid pattern still leads to entry once that pattern completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and pattern-sampling clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data in |
| latch_dm | input | 1 | Latch transparency, high passes; also pattern pin |
| oen_dm | input | 1 | Active-low channel enable; also pattern pin |
| fault_flags | input | 16 | Per-channel fault flag, 1 means open or short |
| ser_out | output | 1 | Last shift stage, for cascading and readback |
| chan_on | output | 16 | Channel-on bits for the current sinks |

## Verification
Some behaviours are checked by assertions on every cycle. These are that the serial path moves one stage per edge, that a capture edge loads exactly the inverted flags, that blanking forces all channels off, and that a closed latch keeps the channels still. They also cover that a repeated pattern never changes the mode and that two captures never occur back to back. The bench scenarios are needed for the rest: the exact five-edge patterns and their overlap, the single capture per diagnostic stay, and the return to normal mode. These can only be seen at the ports through whether a later enable pulse reloads the serial word.

// File: rtl/led_sink_pkg.sv
// Shared constants for the LED driver core: the five-edge mode patterns
// and the mode encoding. Patterns are written oldest edge in the MSB.
package led_sink_pkg;
    localparam int SEQ_LEN = 5;
    localparam logic [SEQ_LEN-1:0] ENTER_OE = 5'b10111;
    localparam logic [SEQ_LEN-1:0] ENTER_LE = 5'b00010;
    localparam logic [SEQ_LEN-1:0] LEAVE_OE = 5'b10111;
    localparam logic [SEQ_LEN-1:0] LEAVE_LE = 5'b00000;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_DIAG   = 1'b1
    } drv_mode_e;
endpackage

// File: rtl/led_mode_seq.sv
// Mode sequencer: keeps the last SEQ_LEN-1 sampled (enable, latch) pairs,
// compares them together with the current pair on every rising edge, and
// toggles between normal and diagnostic mode. It also issues the single
// capture strobe of a diagnostic stay. Assumes the pins are stable around
// each rising edge.
module led_mode_seq
    import led_sink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic le,
    output logic diag,
    output logic capture
);
    localparam int HIST = SEQ_LEN - 1;

    logic [HIST-1:0]    oe_hist;
    logic [HIST-1:0]    le_hist;
    logic [SEQ_LEN-1:0] oe_win;
    logic [SEQ_LEN-1:0] le_win;
    logic               enter_hit;
    logic               leave_hit;
    logic               armed;
    drv_mode_e          mode;

    // Current window of pairs, oldest edge in the MSB.
    always_comb begin
        oe_win    = {oe_hist, oe_n};
        le_win    = {le_hist, le};
        enter_hit = (oe_win == ENTER_OE) && (le_win == ENTER_LE);
        leave_hit = (oe_win == LEAVE_OE) && (le_win == LEAVE_LE);
    end

    // Capture on the first enable rise of an armed diagnostic stay.
    assign capture = (mode == MODE_DIAG) && armed && !oe_hist[0] && oe_n;
    assign diag    = (mode == MODE_DIAG);

    // Pair history; reset fills it with a pair no pattern contains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hist <= '0;
            le_hist <= '1;
        end else begin
            oe_hist <= {oe_hist[HIST-2:0], oe_n};
            le_hist <= {le_hist[HIST-2:0], le};
        end
    end

    // Mode and capture arming; repeated patterns fall through unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_NORMAL;
            armed <= 1'b0;
        end else if (mode == MODE_NORMAL && enter_hit) begin
            mode  <= MODE_DIAG;
            armed <= 1'b1;
        end else if (mode == MODE_DIAG && leave_hit) begin
            mode  <= MODE_NORMAL;
            armed <= 1'b0;
        end else if (capture) begin
            armed <= 1'b0;
        end
    end

    // R6: an entry pattern inside diagnostic mode keeps the mode
    a_r6_enter_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIAG && enter_hit) |=> (mode == MODE_DIAG));
    // R6: a return pattern inside normal mode keeps the mode
    a_r6_leave_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && leave_hit && !enter_hit) |=> (mode == MODE_NORMAL));
    // R8: a capture is never followed by another on the next edge
    a_r8_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);
    // R4: a completed entry pattern in normal mode lands in diagnostic mode
    a_r4_enter_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && enter_hit) |=> diag);
endmodule

// File: rtl/led_shift_chain.sv
// Serial-in, parallel-out chain of WIDTH stages. On a capture strobe the
// whole chain is loaded with the health word instead of shifting.
// Stage WIDTH-1 is the serial output.
module led_shift_chain #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] stages,
    output logic             sdo
);
    // Shift one stage per edge, or take the parallel word on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stages <= '0;
        else if (load)
            stages <= load_word;
        else
            stages <= {stages[WIDTH-2:0], sdi};
    end

    assign sdo = stages[WIDTH-1];

    // R1: without a load, input enters stage 0 and the output takes the old next-to-last stage
    a_r1_serial_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (stages[0] == $past(sdi)) && (sdo == $past(stages[WIDTH-2])));
    // R7: a load edge places the parallel word in the chain
    a_r7_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (stages == $past(load_word)));
endmodule

// File: rtl/led_out_gate.sv
// Output stage: a level-sensitive storage latch fed by the shift chain,
// followed by the active-low enable gate. The latch is transparent while
// le is high and is not tied to the clock; reset clears it.
module led_out_gate #(
    parameter int WIDTH = 16
) (
    input  logic             rst_n,
    input  logic             le,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] stages,
    output logic [WIDTH-1:0] chan_on
);
    logic [WIDTH-1:0] lat_q;

    // Storage latch: follow the chain while open, hold while closed.
    always_latch begin
        if (!rst_n)
            lat_q <= '0;
        else if (le)
            lat_q <= stages;
    end

    // Per-channel enable gate.
    for (genvar i = 0; i < WIDTH; i++) begin : g_chan
        assign chan_on[i] = lat_q[i] & ~oe_n;
    end
endmodule

// File: rtl/led_sink_core.sv
// Top of the LED driver core: shift chain, mode sequencer and output stage.
// Fault flags are sampled on the capture edge and inverted into a health
// word (1 = healthy). Assumes inputs change only between clock edges.
module led_sink_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             latch_dm,
    input  logic             oen_dm,
    input  logic [WIDTH-1:0] fault_flags,
    output logic             ser_out,
    output logic [WIDTH-1:0] chan_on
);
    logic             diag;
    logic             capture;
    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] health;

    // Health word: a raised fault flag reads back as 0.
    assign health = ~fault_flags;

    led_mode_seq u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (oen_dm),
        .le      (latch_dm),
        .diag    (diag),
        .capture (capture)
    );

    led_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (ser_in),
        .load      (capture),
        .load_word (health),
        .stages    (stages),
        .sdo       (ser_out)
    );

    led_out_gate #(.WIDTH(WIDTH)) u_gate (
        .rst_n   (rst_n),
        .le      (latch_dm),
        .oe_n    (oen_dm),
        .stages  (stages),
        .chan_on (chan_on)
    );

    // R3: blanking forces every channel off
    a_r3_blank_all: assert property (@(posedge clk) disable iff (!rst_n)
        oen_dm |-> (chan_on == '0));
    // R2: with the latch closed over two samples and outputs enabled, channels stay put
    a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_dm && !$past(latch_dm) && !oen_dm && !$past(oen_dm)) |-> $stable(chan_on));
    // R8: captures happen only in diagnostic mode
    a_r8_diag_only: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> diag);
endmodule

// File: tb/led_sink_core_bench.sv
module led_sink_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        latch_dm = 1'b0;
    logic        oen_dm = 1'b0;
    logic [15:0] fault_flags = '0;
    logic        ser_out;
    logic [15:0] chan_on;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench reference state, derived from the requirements.
    logic [15:0] m_sr = '0;
    logic [15:0] m_lat = '0;
    bit          m_diag = 0;
    bit          m_arm = 0;
    bit [3:0]    m_oh = 4'b0000;
    bit [3:0]    m_lh = 4'b1111;

    always #2 clk = ~clk;

    led_sink_core u_led_sink_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .latch_dm    (latch_dm),
        .oen_dm      (oen_dm),
        .fault_flags (fault_flags),
        .ser_out     (ser_out),
        .chan_on     (chan_on)
    );

    function automatic logic [15:0] exp_chan(bit oe, logic [15:0] lat);
        return oe ? 16'h0000 : lat;
    endfunction

    task automatic chk(string tag);
        logic [15:0] ec;
        ec = exp_chan(oen_dm, m_lat);
        total++;
        if (chan_on !== ec || ser_out !== m_sr[15]) begin
            bad++;
            $display("FAIL %s: chan_on=%h ser_out=%b expected chan_on=%h ser_out=%b",
                     tag, chan_on, ser_out, ec, m_sr[15]);
        end
    endtask

    // One clock: apply inputs, advance the model at the edge, check after it.
    task automatic step(bit s, bit l, bit o, logic [15:0] f, string tag);
        bit [4:0] ow, lw;
        bit ent, lev, cap;
        ser_in = s; latch_dm = l; oen_dm = o; fault_flags = f;
        if (l) m_lat = m_sr;
        @(posedge clk);
        ow  = {m_oh, o};
        lw  = {m_lh, l};
        ent = (ow == 5'b10111) && (lw == 5'b00010);
        lev = (ow == 5'b10111) && (lw == 5'b00000);
        cap = m_diag && m_arm && !m_oh[0] && o;
        if (cap) m_sr = ~f;
        else     m_sr = {m_sr[14:0], s};
        if (!m_diag && ent) begin m_diag = 1; m_arm = 1; end
        else if (m_diag && lev) begin m_diag = 0; m_arm = 0; end
        else if (cap) m_arm = 0;
        m_oh = {m_oh[2:0], o};
        m_lh = {m_lh[2:0], l};
        if (l) m_lat = m_sr;
        #1;
        chk(tag);
    endtask

    task automatic enter_seq(string tag);
        step(1, 0, 1, 16'h0, tag);
        step(1, 0, 0, 16'h0, tag);
        step(1, 0, 1, 16'h0, tag);
        step(1, 1, 1, 16'h0, tag);
        step(1, 0, 1, 16'h0, tag);
    endtask

    task automatic leave_seq(string tag);
        step(0, 0, 1, 16'h0, tag);
        step(0, 0, 0, 16'h0, tag);
        step(0, 0, 1, 16'h0, tag);
        step(0, 0, 1, 16'h0, tag);
        step(0, 0, 1, 16'h0, tag);
    endtask

    // Load ones, latch, drive channels on, then raise the enable with flags.
    task automatic probe(logic [15:0] f, string tag);
        for (int i = 0; i < 16; i++) step(1, 0, 1, 16'h0, tag);
        step(1, 1, 1, 16'h0, tag);
        step(1, 0, 0, 16'h0, tag);
        step(1, 0, 0, 16'h0, tag);
        step(0, 0, 1, f, tag);
        for (int i = 0; i < 16; i++) step(i[0], 0, 1, 16'h0, tag);
    endtask

    initial begin
        logic [15:0] word;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset");
        rst_n = 1'b1;

        // R1 / R2: shift a word with the latch closed, then open it.
        word = 16'hA5C3;
        for (int i = 15; i >= 0; i--) step(word[i], 0, 0, 16'h0, "R2 closed");
        step(0, 1, 0, 16'h0, "R2 open");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 16'h0, "R1 shift R2 hold");

        // R3: blanking.
        for (int i = 0; i < 4; i++) step(0, 0, 1, 16'h0, "R3 blank");
        step(0, 0, 0, 16'h0, "R3 enable");

        // R4 / R7: enter, probe with two faulty channels, read back.
        enter_seq("R4 enter");
        probe(16'h0810, "R4 R7 capture");

        // R8: a second enable pulse in the same stay does not reload.
        probe(16'hFFFF, "R8 no recapture");

        // R6: repeated entry does not re-arm.
        enter_seq("R6 enter again");
        probe(16'h00FF, "R6 ignored entry");

        // R5: leave, then an enable pulse in normal mode does not capture.
        leave_seq("R5 leave");
        probe(16'hF0F0, "R5 normal no capture");
        leave_seq("R6 leave again");
        probe(16'h1234, "R6 ignored leave");

        // R10: broken attempt overlapping a valid entry.
        step(0, 0, 1, 16'h0, "R10 overlap");
        step(0, 0, 0, 16'h0, "R10 overlap");
        step(0, 0, 1, 16'h0, "R10 overlap");
        step(0, 0, 0, 16'h0, "R10 overlap");
        step(0, 0, 1, 16'h0, "R10 overlap");
        step(0, 1, 1, 16'h0, "R10 overlap");
        step(0, 0, 1, 16'h0, "R10 overlap");
        probe(16'h8001, "R10 R7 capture after overlap");
        leave_seq("R5 leave");

        // Random mix of data, latch and enable activity.
        for (int i = 0; i < 600; i++) begin
            bit s, l, o;
            s = $urandom_range(1, 0);
            l = ($urandom_range(3, 0) == 0);
            o = ($urandom_range(2, 0) == 0);
            step(s, l, o, 16'($urandom), "R1 R2 R3 random");
        end

        // R9: reset mid-stream from diagnostic mode.
        enter_seq("R4 enter");
        rst_n = 1'b0;
        @(posedge clk);
        m_sr = '0; m_lat = '0; m_diag = 0; m_arm = 0; m_oh = '0; m_lh = '1;
        #1;
        ser_in = 0; latch_dm = 0; oen_dm = 0;
        #1;
        chk("R9 reset again");
        rst_n = 1'b1;
        probe(16'h0F0F, "R9 normal after reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule